// File: doc/BRIEF.md
# Byte-Serial Peripheral Master

This block is a byte-wide SPI master. It sits on a small CPU register bus with three registers: control, status and data. Software sets the clock mode and the rate in the control register. A write to the data register then starts an 8-bit exchange. The byte leaves on `mosi`, most significant bit first, and the reply on `miso` is gathered into the receive register.

The serial clock comes from the CPU clock. The half-period is 1, 2, 8 or 16 CPU cycles, selected by the rate field. All four combinations of clock polarity and phase are supported.

When the eighth bit finishes, the block sets a done flag. It can also raise an interrupt. A data write that arrives while a byte is still moving is dropped and recorded as a collision. Software clears the flags in two steps: it reads the status register, then it reads or writes the data register.

Top module: `spim_top`

## Requirements
- R1: Control register (address 0) is read/write and resets to 0x00. Its bits, from 7 down to 0, are: irq enable, system enable, open-drain option (stored only), master, CPOL, CPHA, rate[1:0].
- R2: A data write (address 2) starts a transfer only if system enable and master are both 1 and no transfer is running. Otherwise the write is ignored: no transfer starts and no flag changes.
- R3: With no transfer running, `sck` equals CPOL. Rate codes 0, 1, 2 and 3 give a half-period of 1, 2, 8 and 16 clocks. The first `sck` edge comes H clocks after the write, where H is the half-period. A transfer has 16 edges, and the done flag is visible 16·H clocks after the write.
- R4: `mosi` sends the written byte MSB first. With CPHA=0, bit 7 is on `mosi` before the first edge, `miso` is sampled on the leading edges, and `mosi` changes on the trailing edges. With CPHA=1, `mosi` changes on the leading edges and `miso` is sampled on the trailing edges.
- R5: The eight `miso` samples form a byte, first sample in bit 7. Reading the data register returns this byte once the transfer is complete.
- R6: The done flag is set when the last edge completes. `irq` equals the irq enable bit AND the done flag.
- R7: A data write during a transfer, with the block enabled, sets the collision flag. It does not change the byte being shifted.
- R8: Status register (address 1): bit 7 is done, bit 6 is collision, bit 4 is mode fault (always 0), and all other bits read 0. Writes to it have no effect.
- R9: A status read records which flags are set at that moment. The next data read, or the next accepted data write, clears exactly those recorded flags. Flags set after the status read stay set.
- R10: Reset clears the control register, stops a running transfer, clears both flags and discards any recorded flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together and that each strobe lasts exactly one cycle per access. They also assume that `miso` changes only between sampling edges. The bench drives every access from the falling clock edge for a single cycle. Its slave model changes `miso` only on the opposite edge from the one the design samples, and it disarms before control writes that could move `sck`.

// File: rtl/spim_pkg.sv
package spim_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2
   } spim_reg_e;

   typedef struct packed {
      logic       irq_en;
      logic       sys_en;
      logic       od_opt;
      logic       master;
      logic       cpol;
      logic       cpha;
      logic [1:0] rate;
   } spim_ctrl_t;

   localparam int STAT_DONE_BIT  = 7;
   localparam int STAT_COLL_BIT  = 6;
   localparam int STAT_FAULT_BIT = 4;

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
   parameter int HALF_TAB [4] = '{1, 2, 8, 16}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] rate,
   output logic       tick
);
   localparam int HMAX01 = (HALF_TAB[0] > HALF_TAB[1]) ? HALF_TAB[0] : HALF_TAB[1];
   localparam int HMAX23 = (HALF_TAB[2] > HALF_TAB[3]) ? HALF_TAB[2] : HALF_TAB[3];
   localparam int HMAX   = (HMAX01 > HMAX23) ? HMAX01 : HMAX23;
   localparam int CNT_W  = (HMAX < 2) ? 1 : $clog2(HMAX);

   logic [CNT_W-1:0] lim_tab [4];
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   for (genvar g = 0; g < 4; g++) begin : g_lim
      if (HALF_TAB[g] < 1) begin : g_bad
         $error("spim_clkgen: half-period entries must be at least 1");
      end
      assign lim_tab[g] = CNT_W'(HALF_TAB[g] - 1);
   end

   assign lim  = lim_tab[rate];
   assign tick = run && (cnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         cpol,
   input  logic         cpha,
   input  logic         tick,
   input  logic         miso,
   output logic         busy,
   output logic         done,
   output logic         sck,
   output logic         mosi,
   output logic [W-1:0] rx_data
);
   localparam int EDGES  = 2 * W;
   localparam int EDGE_W = $clog2(EDGES);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

   if (W < 2) begin : g_bad_w
      $error("spim_shifter: word width must be at least 2");
   end

   logic [W-1:0]      tx_sr;
   logic [W-1:0]      rx_sr;
   logic [EDGE_W-1:0] edge_cnt;
   logic              sck_q;
   logic              mosi_q;
   logic              sample_edge;

   // Leading edges have even index; CPHA selects which parity samples.
   assign sample_edge = (edge_cnt[0] == cpha);
   assign done        = busy && tick && (edge_cnt == LAST_EDGE);
   assign sck         = busy ? sck_q : cpol;
   assign mosi        = mosi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         sck_q    <= 1'b0;
         mosi_q   <= 1'b0;
         tx_sr    <= '0;
         rx_sr    <= '0;
         rx_data  <= '0;
         edge_cnt <= '0;
      end else if (load) begin
         busy     <= 1'b1;
         edge_cnt <= '0;
         sck_q    <= cpol;
         if (!cpha) begin
            mosi_q <= load_data[W-1];
            tx_sr  <= load_data << 1;
         end else begin
            tx_sr  <= load_data;
         end
      end else if (busy && tick) begin
         sck_q    <= ~sck_q;
         edge_cnt <= edge_cnt + 1'b1;
         if (sample_edge) begin
            rx_sr <= {rx_sr[W-2:0], miso};
         end else begin
            mosi_q <= tx_sr[W-1];
            tx_sr  <= tx_sr << 1;
         end
         if (edge_cnt == LAST_EDGE) begin
            busy    <= 1'b0;
            rx_data <= sample_edge ? {rx_sr[W-2:0], miso} : rx_sr;
         end
      end
   end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [BUS_W-1:0] bus_wdata,
   input  logic             busy,
   input  logic             done,
   input  logic [BUS_W-1:0] rx_data,
   output spim_ctrl_t       ctrl,
   output logic             load,
   output logic             active,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             irq
);
   logic done_f, coll_f;
   logic cap_done, cap_coll;
   logic data_wr, data_rd, stat_rd, collide, data_touch;
   logic [BUS_W-1:0] stat_byte;

   assign active     = ctrl.sys_en && ctrl.master;
   assign data_wr    = bus_wr && (bus_addr == REG_DATA) && active;
   assign data_rd    = bus_rd && (bus_addr == REG_DATA);
   assign stat_rd    = bus_rd && (bus_addr == REG_STAT);
   assign load       = data_wr && !busy;
   assign collide    = data_wr && busy;
   assign data_touch = data_wr || data_rd;

   always_comb begin
      stat_byte                 = '0;
      stat_byte[STAT_DONE_BIT]  = done_f;
      stat_byte[STAT_COLL_BIT]  = coll_f;
      stat_byte[STAT_FAULT_BIT] = 1'b0;
   end

   always_comb begin
      case (bus_addr)
         REG_CTRL: bus_rdata = BUS_W'(ctrl);
         REG_STAT: bus_rdata = stat_byte;
         REG_DATA: bus_rdata = rx_data;
         default:  bus_rdata = '0;
      endcase
   end

   assign irq = ctrl.irq_en && done_f;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         done_f   <= 1'b0;
         coll_f   <= 1'b0;
         cap_done <= 1'b0;
         cap_coll <= 1'b0;
      end else begin
         if (bus_wr && (bus_addr == REG_CTRL)) begin
            ctrl <= spim_ctrl_t'(bus_wdata[7:0]);
         end
         if (stat_rd) begin
            cap_done <= done_f;
            cap_coll <= coll_f;
         end else if (data_touch) begin
            cap_done <= 1'b0;
            cap_coll <= 1'b0;
         end
         // Clearing recorded flags comes first; a new event in the same cycle wins.
         done_f <= (done_f && !(data_touch && cap_done)) || done;
         coll_f <= (coll_f && !(data_touch && cap_coll)) || collide;
      end
   end
endmodule

// File: rtl/spim_top.sv
module spim_top
   import spim_pkg::*;
#(
   parameter int BUS_W        = 8,
   parameter int HALF_TAB [4] = '{1, 2, 8, 16}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             irq,
   output logic             sck,
   output logic             mosi,
   input  logic             miso
);
   if (BUS_W != $bits(spim_ctrl_t)) begin : g_bad_bus
      $error("spim_top: bus width must match the control register width");
   end

   spim_ctrl_t       ctrl;
   logic             load, active, busy, done, tick;
   logic [BUS_W-1:0] rx_data;

   spim_regs #(.BUS_W(BUS_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .busy      (busy),
      .done      (done),
      .rx_data   (rx_data),
      .ctrl      (ctrl),
      .load      (load),
      .active    (active),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   spim_clkgen #(.HALF_TAB(HALF_TAB)) u_clk (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .rate  (ctrl.rate),
      .tick  (tick)
   );

   spim_shifter #(.W(BUS_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (bus_wdata),
      .cpol      (ctrl.cpol),
      .cpha      (ctrl.cpha),
      .tick      (tick),
      .miso      (miso),
      .busy      (busy),
      .done      (done),
      .sck       (sck),
      .mosi      (mosi),
      .rx_data   (rx_data)
   );
endmodule

// File: rtl/spim_chk.sv
module spim_chk
   import spim_pkg::*;
#(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   bus_addr,
   input logic         bus_wr,
   input logic         busy,
   input logic         tick,
   input logic         done,
   input logic         active,
   input logic         sck,
   input logic         spif,
   input logic         wcol,
   input logic [W-1:0] tx_sr
);
   // R8
   stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_STAT && !done) |=> ($stable(spif) && $stable(wcol)));

   // R6
   spif_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spif) |-> $past(done));

   // R7
   wcol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wcol) |-> $past(bus_wr && bus_addr == REG_DATA && busy));

   // R7
   coll_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wr && bus_addr == REG_DATA && !tick) |=> $stable(tx_sr));

   // R2
   idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && bus_wr && bus_addr == REG_DATA && !active) |=> !busy);

   // R3
   sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(sck));
endmodule

bind spim_top spim_chk #(.W(BUS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .busy     (busy),
   .tick     (tick),
   .done     (done),
   .active   (active),
   .sck      (sck),
   .spif     (u_regs.done_f),
   .wcol     (u_regs.coll_f),
   .tx_sr    (u_shift.tx_sr)
);

// File: tb/sim_spim_top.sv
module sim_spim_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq, sck, mosi;
   logic       miso;

   int n_chk = 0;
   int n_fail = 0;

   // slave model state
   logic       sl_go = 1'b0;
   logic       sl_go_seen = 1'b0;
   logic       sl_arm = 1'b0;
   logic       sl_cpha = 1'b0;
   logic [7:0] sl_byte = 8'h00;
   logic [7:0] sl_tx = 8'h00;
   logic [7:0] sl_rx = 8'h00;
   int         sl_n = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spim_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
   );

   initial miso = 1'b0;
   always begin
      @(sck or sl_go);
      if (sl_go != sl_go_seen) begin
         sl_go_seen = sl_go;
         sl_n  = 0;
         sl_rx = 8'h00;
         if (!sl_cpha) begin
            miso  = sl_byte[7];
            sl_tx = sl_byte << 1;
         end else begin
            sl_tx = sl_byte;
         end
      end else if (sl_arm) begin
         sl_n++;
         if ((sl_n % 2 == 1) == sl_cpha) begin
            miso  = sl_tx[7];
            sl_tx = sl_tx << 1;
         end else begin
            sl_rx = {sl_rx[6:0], mosi};
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   function automatic int half_of(input logic [1:0] r);
      case (r)
         2'd0: return 1;
         2'd1: return 2;
         2'd2: return 8;
         default: return 16;
      endcase
   endfunction

   task automatic clear_flags();
      logic [7:0] d;
      bus_read(2'd1, d);
      bus_read(2'd2, d);
   endtask

   task automatic slave_setup(input logic cpha, input logic [7:0] b);
      sl_cpha = cpha; sl_byte = b;
      sl_go = ~sl_go;
      #1 sl_arm = 1'b1;
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      bus_read(2'd0, d); chk("R1 ctrl reset", d, 8'h00);
      bus_read(2'd1, d); chk("R8 stat reset", d, 8'h00);
      chk("R6 irq reset", irq, 1'b0);
      chk("R3 sck idle at reset", sck, 1'b0);
      bus_write(2'd0, 8'h7E);
      bus_read(2'd0, d); chk("R1 ctrl readback", d, 8'h7E);
      bus_write(2'd0, 8'h00);
   endtask

   task automatic t_modes();
      logic [7:0] d;
      logic [7:0] txv [4] = '{8'hA5, 8'h3C, 8'h81, 8'h5E};
      logic [7:0] slv [4] = '{8'h6B, 8'hC3, 8'h17, 8'hF0};
      for (int m = 0; m < 4; m++) begin
         sl_arm = 1'b0;
         bus_write(2'd0, {4'b1101, m[1], m[0], 2'b00});
         chk("R3 idle sck equals CPOL", sck, m[1]);
         slave_setup(m[0], slv[m]);
         bus_write(2'd2, txv[m]);
         repeat (20) @(negedge clk);
         chk("R4 mosi byte MSB first", sl_rx, txv[m]);
         chk("R6 irq on completion", irq, 1'b1);
         chk("R3 sck back to CPOL", sck, m[1]);
         bus_read(2'd1, d); chk("R8 stat shows done", d, 8'h80);
         bus_read(2'd2, d); chk("R5 received byte", d, slv[m]);
         chk("R9 irq cleared by sequence", irq, 1'b0);
      end
      sl_arm = 1'b0;
   endtask

   task automatic t_timing();
      for (int r = 0; r < 4; r++) begin
         int h;
         h = half_of(r[1:0]);
         bus_write(2'd0, {6'b110100, r[1:0]});
         bus_write(2'd2, 8'h55);
         repeat (h - 1) @(negedge clk);
         chk("R3 sck held before first edge", sck, 1'b0);
         @(negedge clk);
         chk("R3 first edge after one half-period", sck, 1'b1);
         repeat (15 * h - 1) @(negedge clk);
         chk("R3 done not yet before 16 half-periods", irq, 1'b0);
         @(negedge clk);
         chk("R3 done after 16 half-periods", irq, 1'b1);
         clear_flags();
      end
   endtask

   task automatic t_collision();
      logic [7:0] d;
      sl_arm = 1'b0;
      bus_write(2'd0, 8'h51);
      slave_setup(1'b0, 8'h99);
      bus_write(2'd2, 8'hA5);
      bus_write(2'd2, 8'h3C);
      repeat (80) @(negedge clk);
      chk("R7 collided write not shifted", sl_rx, 8'hA5);
      bus_read(2'd1, d); chk("R7 collision and done flags", d, 8'hC0);
      bus_read(2'd2, d); chk("R5 byte after collision", d, 8'h99);
      bus_read(2'd1, d); chk("R9 both recorded flags cleared", d, 8'h00);
      sl_arm = 1'b0;
   endtask

   task automatic t_clear_order();
      logic [7:0] d;
      bus_write(2'd0, 8'hD1);
      bus_write(2'd2, 8'h12);
      bus_read(2'd1, d); chk("R9 status empty mid-transfer", d, 8'h00);
      repeat (60) @(negedge clk);
      bus_read(2'd2, d);
      chk("R9 later flag survives data read", irq, 1'b1);
      bus_read(2'd1, d); chk("R9 status still done", d, 8'h80);
      bus_write(2'd1, 8'h00);
      bus_read(2'd1, d); chk("R8 status write no effect", d, 8'h80);
      bus_read(2'd2, d);
      bus_read(2'd1, d); chk("R9 cleared after sequence", d, 8'h00);
   endtask

   task automatic t_disabled();
      logic [7:0] d;
      bus_write(2'd0, 8'h98);
      bus_write(2'd2, 8'hFF);
      repeat (40) @(negedge clk);
      bus_read(2'd1, d); chk("R2 write ignored when disabled", d, 8'h00);
      chk("R2 sck idle when disabled", sck, 1'b1);
      bus_write(2'd0, 8'hC0);
      bus_write(2'd2, 8'hFF);
      repeat (40) @(negedge clk);
      bus_read(2'd1, d); chk("R2 write ignored without master", d, 8'h00);
      chk("R2 irq stays low", irq, 1'b0);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      bus_write(2'd0, 8'hD0);
      bus_write(2'd2, 8'h77);
      repeat (30) @(negedge clk);
      bus_read(2'd1, d);
      chk("R10 done before reset", d, 8'h80);
      bus_write(2'd0, 8'hDB);
      bus_write(2'd2, 8'h44);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (600) @(negedge clk);
      bus_read(2'd0, d); chk("R10 ctrl cleared", d, 8'h00);
      bus_read(2'd1, d); chk("R10 flags cleared, transfer aborted", d, 8'h00);
      chk("R10 sck idle after reset", sck, 1'b0);
      bus_write(2'd0, 8'hD0);
      bus_write(2'd2, 8'h21);
      repeat (30) @(negedge clk);
      bus_read(2'd2, d);
      chk("R10 recorded flags discarded", irq, 1'b1);
      clear_flags();
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_modes();
      t_timing();
      t_collision();
      t_clear_order();
      t_disabled();
      t_reset();
      finish_run();
   end
endmodule